// File: doc/BRIEF.md
# Self-Clearing Calibration Request Controller

This block sits on the register side of a receiver and runs two calibration routines on request: a polling-timer calibration and an FSK receiver calibration. Software starts a routine by writing a 1 into that routine's request bit in a configuration register. The controller then sends a one-cycle start pulse to the matching calibration engine and waits for the engine's completion pulse. On completion it clears the request bit by itself and raises a sticky completion flag in a read-only status register. Software therefore polls either the request bit falling or the flag rising.

The FSK routine is started in two writes. The first write sets an accuracy-select bit, which picks a long precise run or a short coarse one. The second write sets the FSK request. Each calibration engine is modelled inside the block as a down-counter of fixed length. An auto-start input, pulsed once per wake-up when the receiver runs in duty-cycled mode, starts both routines at once. In continuous reception the routines run only when software asks for them.

The register port is a plain single-cycle write strobe with address and data. Reads are combinational from the address. The bus protocol in front of it is not part of this block.

Top module: `cal_handshake`

## Requirements
- R1: After reset, the configuration register (address 1) and the status register (address 9) both read 0, and no calibration is running.
- R2: The configuration register has this layout: bit 0 is the polling-calibration request, bit 1 is the FSK-calibration request, and bit 2 is the accuracy select (1 = full accuracy, 0 = fast). Bit 2 reads back the last value written. All other bits read 0.
- R3: A write with bit 0 set, made while no polling calibration is running, starts one. Bit 0 then reads 1 for exactly POLL_CYC cycles after the write edge. It returns to 0 on the same edge that sets status bit 0.
- R4: A write with bit 1 set, made while no FSK calibration is running, starts one. Bit 1 reads 1 for FSK_FAST_CYC cycles when the accuracy bit is 0, and for FSK_FAST_CYC*FSK_FULL_MULT cycles (4x by default) when it is 1. The accuracy value used is the one in force after the starting write. The request then clears on the same edge that sets status bit 1.
- R5: A status flag stays at 1 until a new calibration of the same kind starts. That start clears it on the start edge and leaves the other flag unchanged.
- R6: While a calibration runs, further writes to its request bit (1 or 0) neither restart it nor abort it. A change to the accuracy bit during an FSK run does not change that run's length.
- R7: The status register is read-only, and writes to address 9 change nothing. Addresses other than 1 and 9 read 0, and writes to them are ignored.
- R8: A one-cycle pulse on auto_cal starts every routine that is not already running. The FSK length follows the stored accuracy bit.
- R9: A configuration write with a request bit at 0 does not start that routine. It only updates the accuracy bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_cal | input | 1 | Wake-up pulse that starts both calibrations |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for both read and write |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data for addr |

## Verification
Faults in the internal state show up at the ports as a wrong run length. A request bit that falls one cycle early or late, or at the wrong accuracy, appears as a miscounted number of cycles during which the request bit reads 1. This is visible within a single run of at most FSK_FAST_CYC*FSK_FULL_MULT cycles. A lost or spurious completion flag appears on the first status read after the request falls. A flag that fails to clear on a restart appears one cycle after the start edge. The bench disturbs running calibrations with random rewrites and accuracy flips, so that a restart or abort path changes the measured count.

// File: rtl/cal_handshake.sv
module cal_handshake #(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 8,
  parameter int CFG_ADDR      = 1,
  parameter int STAT_ADDR     = 9,
  parameter int POLL_CYC      = 24,
  parameter int FSK_FAST_CYC  = 10,
  parameter int FSK_FULL_MULT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_cal,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int FSK_FULL_CYC = FSK_FAST_CYC * FSK_FULL_MULT;
  localparam int MAX_CYC = (POLL_CYC > FSK_FULL_CYC) ? POLL_CYC : FSK_FULL_CYC;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  logic             poll_en, fsk_en, acc_q;
  logic             poll_done, fsk_done;
  logic             poll_run, fsk_run;
  logic [CNT_W-1:0] poll_cnt, fsk_cnt;

  wire cfg_wr    = wr_en && (addr == ADDR_W'(CFG_ADDR));
  wire acc_next  = cfg_wr ? wr_data[2] : acc_q;

  // controller start pulses to the engines
  wire poll_go   = !poll_en && (auto_cal || (cfg_wr && wr_data[0]));
  wire fsk_go    = !fsk_en  && (auto_cal || (cfg_wr && wr_data[1]));

  // engine completion pulses back to the controller
  wire poll_fin  = poll_run && (poll_cnt == '0);
  wire fsk_fin   = fsk_run  && (fsk_cnt  == '0);

  wire [CNT_W-1:0] fsk_len = acc_next ? CNT_W'(FSK_FULL_CYC - 1) : CNT_W'(FSK_FAST_CYC - 1);

  // polling-timer calibration engine
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poll_run <= 1'b0;
      poll_cnt <= '0;
    end else if (poll_go) begin
      poll_run <= 1'b1;
      poll_cnt <= CNT_W'(POLL_CYC - 1);
    end else if (poll_fin) begin
      poll_run <= 1'b0;
    end else if (poll_run) begin
      poll_cnt <= poll_cnt - 1'b1;
    end
  end

  // FSK receiver calibration engine
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsk_run <= 1'b0;
      fsk_cnt <= '0;
    end else if (fsk_go) begin
      fsk_run <= 1'b1;
      fsk_cnt <= fsk_len;
    end else if (fsk_fin) begin
      fsk_run <= 1'b0;
    end else if (fsk_run) begin
      fsk_cnt <= fsk_cnt - 1'b1;
    end
  end

  // register-side handshake
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= 1'b0;
      poll_en   <= 1'b0;
      fsk_en    <= 1'b0;
      poll_done <= 1'b0;
      fsk_done  <= 1'b0;
    end else begin
      acc_q <= acc_next;
      if (poll_go) begin
        poll_en   <= 1'b1;
        poll_done <= 1'b0;
      end else if (poll_fin) begin
        poll_en   <= 1'b0;
        poll_done <= 1'b1;
      end
      if (fsk_go) begin
        fsk_en   <= 1'b1;
        fsk_done <= 1'b0;
      end else if (fsk_fin) begin
        fsk_en   <= 1'b0;
        fsk_done <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(CFG_ADDR))
      rd_data[2:0] = {acc_q, fsk_en, poll_en};
    else if (addr == ADDR_W'(STAT_ADDR))
      rd_data[1:0] = {fsk_done, poll_done};
  end
endmodule

module cal_handshake_chk #(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 9,
  parameter int CNT_W     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              auto_cal,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              poll_en,
  input logic              fsk_en,
  input logic              poll_done,
  input logic              fsk_done,
  input logic [CNT_W-1:0]  poll_cnt,
  input logic [CNT_W-1:0]  fsk_cnt
);
  assert_poll_done_on_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(poll_en) |-> poll_done);
  assert_fsk_done_on_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsk_en) |-> fsk_done);
  assert_poll_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(poll_en) |-> !poll_done);
  assert_fsk_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsk_en) |-> !fsk_done);
  assert_poll_no_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_en && poll_cnt != '0) |=> poll_en);
  assert_fsk_no_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fsk_en && fsk_cnt != '0) |=> fsk_en);
  assert_status_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(STAT_ADDR) && !auto_cal && !poll_en && !fsk_en)
      |=> ($stable(poll_done) && $stable(fsk_done)));
  assert_auto_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cal && !poll_en && !fsk_en) |=> (poll_en && fsk_en));
endmodule

bind cal_handshake cal_handshake_chk #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .auto_cal(auto_cal), .wr_en(wr_en), .addr(addr),
  .poll_en(poll_en), .fsk_en(fsk_en), .poll_done(poll_done), .fsk_done(fsk_done),
  .poll_cnt(poll_cnt), .fsk_cnt(fsk_cnt)
);

// File: tb/test_cal_handshake.sv
module test_cal_handshake;
  localparam int POLL = 24;
  localparam int FAST = 10;
  localparam int MULT = 4;
  localparam logic [3:0] CFG = 4'd1, STAT = 4'd9;

  logic clk = 1'b0, rst_n = 1'b0, auto_cal = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  int checks = 0, errors = 0;
  bit m_acc = 1'b0;

  cal_handshake i_cal_handshake (
    .clk(clk), .rst_n(rst_n), .auto_cal(auto_cal), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  function automatic int fsk_len(input bit acc);
    return acc ? FAST * MULT : FAST;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    if (a == CFG) m_acc = d[2];
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Starts a run (by write or auto pulse) and counts cycles each request reads 1.
  task automatic run_cal(input bit use_auto, input bit p, input bit f, input bit disturb,
                         output int pl, output int fl);
    logic [7:0] r;
    if (use_auto) auto_cal = 1'b1;
    else begin
      wr_en = 1'b1; addr = CFG; wr_data = {5'b0, m_acc, f, p};
    end
    @(posedge clk); @(negedge clk);
    auto_cal = 1'b0; wr_en = 1'b0;
    pl = 0; fl = 0;
    for (int i = 0; i < 500; i++) begin
      rd(CFG, r);
      if (r[0]) pl++;
      if (r[1]) fl++;
      if (!r[0] && !r[1]) break;
      if (disturb && ($urandom % 3) == 0) begin
        wr_en = 1'b1;
        wr_data = {5'b0, 1'($urandom % 2), r[1] & 1'($urandom % 2), r[0] & 1'($urandom % 2)};
        m_acc = wr_data[2];
      end
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int pl, fl, exp_f;
    bit p, f, au, dis;
    void'($urandom(32'd1471));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(CFG, r);  check(r == 8'h00, "R1 config after reset", r, 0);
    rd(STAT, r); check(r == 8'h00, "R1 status after reset", r, 0);

    // R9 / R2: accuracy-only write starts nothing, reads back
    wr(CFG, 8'hFC);
    rd(CFG, r);  check(r == 8'h04, "R9 R2 accuracy-only write", r, 4);
    rd(STAT, r); check(r == 8'h00, "R9 no completion", r, 0);

    // R3: polling calibration length and completion
    run_cal(1'b0, 1'b1, 1'b0, 1'b0, pl, fl);
    check(pl == POLL, "R3 poll run length", pl, POLL);
    rd(STAT, r); check(r == 8'h01, "R3 poll done flag", r, 1);

    // R4: full accuracy FSK
    run_cal(1'b0, 1'b0, 1'b1, 1'b0, pl, fl);
    check(fl == FAST * MULT, "R4 full-accuracy length", fl, FAST * MULT);
    rd(STAT, r); check(r == 8'h03, "R4 fsk done flag", r, 3);

    // R7: status writes and unmapped addresses ignored
    wr(STAT, 8'h00);
    rd(STAT, r); check(r == 8'h03, "R7 status write ignored", r, 3);
    wr(4'd3, 8'hFF);
    rd(4'd3, r); check(r == 8'h00, "R7 unmapped reads zero", r, 0);
    rd(CFG, r);  check(r == 8'h04, "R7 unmapped write no effect", r, 4);

    // R5: new poll start clears only the poll flag
    wr_en = 1'b1; addr = CFG; wr_data = 8'h05;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    rd(STAT, r); check(r == 8'h02, "R5 start clears own flag only", r, 2);
    for (int i = 0; i < 100; i++) begin
      rd(CFG, r);
      if (!r[0]) break;
      @(negedge clk);
    end
    rd(STAT, r); check(r == 8'h03, "R5 flag set again", r, 3);

    // R4: fast FSK after two-step setup
    wr(CFG, 8'h00);
    run_cal(1'b0, 1'b0, 1'b1, 1'b0, pl, fl);
    check(fl == FAST, "R4 fast length", fl, FAST);

    // R8: auto start both
    run_cal(1'b1, 1'b0, 1'b0, 1'b0, pl, fl);
    check(pl == POLL, "R8 auto poll length", pl, POLL);
    check(fl == FAST, "R8 auto fsk length", fl, FAST);
    rd(STAT, r); check(r == 8'h03, "R8 auto flags", r, 3);

    // random mix, R6 disturbance during runs
    for (int it = 0; it < 24; it++) begin
      au = ($urandom % 4) == 0;
      p = au ? 1'b1 : 1'($urandom % 2);
      f = au ? 1'b1 : (p ? 1'($urandom % 2) : 1'b1);
      dis = 1'($urandom % 2);
      wr(CFG, {5'b0, 1'($urandom % 2), 2'b00});
      rd(CFG, r); check(r[1:0] == 2'b00, "R9 step-one write idle", r, 0);
      exp_f = fsk_len(m_acc);
      run_cal(au, p, f, dis, pl, fl);
      check(pl == (p ? POLL : 0), "R6 R3 poll length under rewrites", pl, p ? POLL : 0);
      check(fl == (f ? exp_f : 0), "R6 R4 fsk length under rewrites", fl, f ? exp_f : 0);
      rd(CFG, r); check(r[2] == m_acc, "R2 accuracy readback", r[2], m_acc);
      rd(STAT, r);
      if (p) check(r[0], "R3 poll flag after run", r, 1);
      if (f) check(r[1], "R4 fsk flag after run", r, 2);
      repeat ($urandom % 4) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule